// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a watchdog built around a free-running counter that advances on a clock-enable tick. Software must keep the counter from wrapping by writing a two-step service sequence to a key register: an arming value followed directly by a clearing value. Only that exact pair clears the counter. A stray value cancels the armed state, so a lone clearing value that follows it does nothing.

A control register holds a run enable and a reset-mode enable. It also carries a check field that every write must fill with a fixed pattern. When reset mode is on, a counter wrap or a control write with the wrong check pattern produces a one-cycle reset request and sets a sticky cause flag. Software reads the cause flag after a reset and clears it by writing a one. A system reset leaves the flag alone. Only a power-on reset or the software clear removes it.

All writes use one single-cycle strobe with a 2-bit address: 0 selects the key register, 1 the control register and 2 the status register. Address 3 is ignored.

Top module: `keyed_wdog`

## Requirements
- R1: After power-on reset the count is 0, the key sequence is disarmed, run and reset mode are both 1, `rst_req` is 0 and `cause_flag` is 0.
- R2: While run is 1, each cycle with `tick` high raises the count by one, visible after the next rising edge. With `tick` low the count holds.
- R3: A key write (address 0) of 0x55 arms the sequence. A key write of 0xAA while armed clears the count to 0 and disarms, so a second 0xAA does nothing.
- R4: A key write of 0xAA while disarmed leaves the count and the state unchanged.
- R5: Repeated 0x55 key writes keep the sequence armed, and a later 0xAA still clears the count.
- R6: A key write of any value other than 0x55 or 0xAA leaves the count alone but disarms the sequence, so a following 0xAA is ignored.
- R7: With reset mode on, a tick at count 255 wraps the count to 0, pulses `rst_req` high for exactly one cycle and sets `cause_flag`.
- R8: A control write (address 1) whose bits [4:2] are not 3'b101 pulses `rst_req` for one cycle and sets `cause_flag` when reset mode is on. It leaves run (bit 0) and reset mode (bit 1) unchanged.
- R9: With reset mode 0 (bit 1 of a valid control write), neither a wrap nor a bad check write raises `rst_req` or sets `cause_flag`.
- R10: `cause_flag` holds until a status write (address 2) with bit 0 set clears it. A status write with bit 0 clear has no effect. `rst_n` does not clear it, `por_n` does, and a set flag does not block further `rst_req` pulses.
- R11: A clearing key write in the same cycle as a tick wins: the count becomes 0, and at count 255 no wrap or reset request follows. A non-clearing key write does not stop the increment.
- R12: A valid control write with bit 0 = 0 stops counting, so ticks are ignored. Writing bit 0 = 1 restarts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset; the cause flag is kept |
| por_n | input | 1 | Asynchronous active-low power-on reset; clears everything |
| tick | input | 1 | Count enable |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 2 | Write address: 0 key, 1 control, 2 status |
| wr_data | input | 8 | Write data |
| wdog_count | output | 8 | Current counter value |
| rst_req | output | 1 | One-cycle reset request pulse |
| cause_flag | output | 1 | Sticky watchdog-reset cause flag |

## Verification
Every result of this block is due exactly one rising edge after the cycle that carries the stimulus. The count, the armed state, the control fields, `rst_req` and `cause_flag` are all registered, and `rst_req` is high for exactly that one following cycle. The driver applies each write or tick on a falling edge. It tags the expected count, request and flag with the index of the next rising edge. The monitor compares them on the falling edge after that rising edge, which keeps every sample half a period away from the edge that changes the outputs. The same stamping checks that the request pulse is gone one cycle later.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   typedef enum logic [1:0] {
      ADDR_KEY  = 2'd0,
      ADDR_CTRL = 2'd1,
      ADDR_STAT = 2'd2,
      ADDR_NONE = 2'd3
   } wd_addr_e;

   typedef enum logic {
      KEY_IDLE  = 1'b0,
      KEY_ARMED = 1'b1
   } key_state_e;

endpackage

// File: rtl/wdog_key_fsm.sv
module wdog_key_fsm
   import wdog_pkg::*;
#(
   parameter int                KEY_W   = 8,
   parameter logic [KEY_W-1:0]  ARM_KEY = 'h55,
   parameter logic [KEY_W-1:0]  CLR_KEY = 'hAA
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             key_wr,
   input  logic [KEY_W-1:0] key_data,
   output logic             clr_pulse,
   output logic             armed
);

   key_state_e state_q;

   initial begin
      assert (ARM_KEY != CLR_KEY) else $error("arm and clear keys must differ");
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)
         state_q <= KEY_IDLE;
      else if (key_wr)
         state_q <= (key_data == ARM_KEY) ? KEY_ARMED : KEY_IDLE;
   end

   assign armed     = (state_q == KEY_ARMED);
   assign clr_pulse = key_wr && armed && (key_data == CLR_KEY);

   // R5
   arm_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (key_wr && key_data == ARM_KEY) |=> armed);

   // R6
   disarm_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (key_wr && key_data != ARM_KEY) |=> !armed);

   // R4
   key_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
      !key_wr |=> $stable(armed));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             inc,
   input  logic             clr,
   output logic [CNT_W-1:0] count,
   output logic             ovf
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   initial begin
      assert (CNT_W >= 2) else $error("counter must be at least 2 bits");
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)
         count <= '0;
      else if (clr)
         count <= '0;
      else if (inc)
         count <= count + CNT_W'(1);
   end

   assign ovf = inc && !clr && (count == CNT_MAX);

   // R3
   clr_zero_chk: assert property (@(posedge clk) disable iff (!arst_n)
      clr |=> (count == '0));

   // R2
   inc_step_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (inc && !clr) |=> (count == CNT_W'($past(count) + 1)));

   // R12
   hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (!inc && !clr) |=> $stable(count));

   // R7
   ovf_wrap_chk: assert property (@(posedge clk) disable iff (!arst_n)
      ovf |=> (count == '0));

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl #(
   parameter int               DATA_W         = 8,
   parameter int               CHK_W          = 3,
   parameter int               CHK_LSB        = 2,
   parameter logic [CHK_W-1:0] CHK_VAL        = 'b101,
   parameter int               RUN_BIT        = 0,
   parameter int               MODE_BIT       = 1,
   parameter bit               RST_MODE_FIXED = 1'b0,
   parameter bit               RUN_DEFAULT    = 1'b1
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              por_n,
   input  logic              ctrl_wr,
   input  logic [DATA_W-1:0] ctrl_data,
   input  logic              flag_clr,
   input  logic              ovf,
   output logic              run,
   output logic              rst_mode,
   output logic              rst_req,
   output logic              cause_flag
);

   localparam int CHK_MSB = CHK_LSB + CHK_W - 1;

   logic chk_ok;
   logic bad_chk;
   logic fire;
   logic unused_data;

   initial begin
      assert (CHK_MSB < DATA_W) else $error("check field outside data word");
      assert (RUN_BIT < DATA_W && MODE_BIT < DATA_W) else $error("control bit outside data word");
      assert (RUN_BIT != MODE_BIT) else $error("run and mode bits overlap");
      assert (RUN_BIT < CHK_LSB || RUN_BIT > CHK_MSB) else $error("run bit inside check field");
   end

   assign chk_ok      = (ctrl_data[CHK_MSB:CHK_LSB] == CHK_VAL);
   assign bad_chk     = ctrl_wr && !chk_ok;
   assign unused_data = ^ctrl_data;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)
         run <= RUN_DEFAULT;
      else if (ctrl_wr && chk_ok)
         run <= ctrl_data[RUN_BIT];
   end

   generate
      if (RST_MODE_FIXED) begin : g_mode_fixed
         assign rst_mode = 1'b1;
      end else begin : g_mode_prog
         logic mode_q;
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n)
               mode_q <= 1'b1;
            else if (ctrl_wr && chk_ok)
               mode_q <= ctrl_data[MODE_BIT];
         end
         assign rst_mode = mode_q;
      end
   endgenerate

   assign fire = rst_mode && (ovf || bad_chk);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)
         rst_req <= 1'b0;
      else
         rst_req <= fire;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         cause_flag <= 1'b0;
      else if (fire)
         cause_flag <= 1'b1;
      else if (flag_clr)
         cause_flag <= 1'b0;
   end

   // R7
   req_flag_chk: assert property (@(posedge clk) disable iff (!arst_n)
      rst_req |-> cause_flag);

   // R10
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
      (cause_flag && !flag_clr) |=> cause_flag);

   // R8
   badchk_req_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (rst_mode && bad_chk) |=> rst_req);

   // R8
   ctrl_keep_chk: assert property (@(posedge clk) disable iff (!arst_n)
      bad_chk |=> ($stable(run) && $stable(rst_mode)));

   // R9
   nomode_chk: assert property (@(posedge clk) disable iff (!arst_n)
      !rst_mode |=> !rst_req);

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
   import wdog_pkg::*;
#(
   parameter int                CNT_W          = 8,
   parameter int                DATA_W         = 8,
   parameter logic [DATA_W-1:0] ARM_KEY        = 'h55,
   parameter logic [DATA_W-1:0] CLR_KEY        = 'hAA,
   parameter int                CHK_W          = 3,
   parameter int                CHK_LSB        = 2,
   parameter logic [CHK_W-1:0]  CHK_VAL        = 'b101,
   parameter int                RUN_BIT        = 0,
   parameter int                MODE_BIT       = 1,
   parameter int                FLAG_CLR_BIT   = 0,
   parameter bit                RST_MODE_FIXED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CNT_W-1:0]  wdog_count,
   output logic              rst_req,
   output logic              cause_flag
);

   wd_addr_e addr;
   logic     arst_n;
   logic     key_wr;
   logic     ctrl_wr;
   logic     flag_clr;
   logic     clr_pulse;
   logic     armed;
   logic     run;
   logic     rst_mode;
   logic     inc;
   logic     ovf;

   initial begin
      assert (FLAG_CLR_BIT < DATA_W) else $error("flag clear bit outside data word");
   end

   assign arst_n   = rst_n & por_n;
   assign addr     = wd_addr_e'(wr_addr);
   assign key_wr   = wr_en && (addr == ADDR_KEY);
   assign ctrl_wr  = wr_en && (addr == ADDR_CTRL);
   assign flag_clr = wr_en && (addr == ADDR_STAT) && wr_data[FLAG_CLR_BIT];
   assign inc      = tick && run;

   wdog_key_fsm #(
      .KEY_W   (DATA_W),
      .ARM_KEY (ARM_KEY),
      .CLR_KEY (CLR_KEY)
   ) u_key (
      .clk       (clk),
      .arst_n    (arst_n),
      .key_wr    (key_wr),
      .key_data  (wr_data),
      .clr_pulse (clr_pulse),
      .armed     (armed)
   );

   wdog_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk    (clk),
      .arst_n (arst_n),
      .inc    (inc),
      .clr    (clr_pulse),
      .count  (wdog_count),
      .ovf    (ovf)
   );

   wdog_ctrl #(
      .DATA_W         (DATA_W),
      .CHK_W          (CHK_W),
      .CHK_LSB        (CHK_LSB),
      .CHK_VAL        (CHK_VAL),
      .RUN_BIT        (RUN_BIT),
      .MODE_BIT       (MODE_BIT),
      .RST_MODE_FIXED (RST_MODE_FIXED),
      .RUN_DEFAULT    (1'b1)
   ) u_ctrl (
      .clk        (clk),
      .arst_n     (arst_n),
      .por_n      (por_n),
      .ctrl_wr    (ctrl_wr),
      .ctrl_data  (wr_data),
      .flag_clr   (flag_clr),
      .ovf        (ovf),
      .run        (run),
      .rst_mode   (rst_mode),
      .rst_req    (rst_req),
      .cause_flag (cause_flag)
   );

   // R11
   clr_wins_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (key_wr && armed && wr_data == CLR_KEY) |=> (wdog_count == '0 && !rst_req));

   // R3
   clr_disarm_chk: assert property (@(posedge clk) disable iff (!arst_n)
      clr_pulse |=> !armed);

endmodule

// File: tb/tb_keyed_wdog.sv
`timescale 1ns/1ps
module tb_keyed_wdog;

   typedef struct {
      int         due;
      logic [7:0] cnt;
      logic       rq;
      logic       fl;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       por_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] wdog_count;
   logic       rst_req;
   logic       cause_flag;

   exp_t q[$];
   int   cyc = 0;
   int   checks = 0;
   int   errors = 0;

   int   m_cnt = 0;
   logic m_armed = 1'b0;
   logic m_run = 1'b1;
   logic m_mode = 1'b1;
   logic m_rq = 1'b0;
   logic m_flag = 1'b0;

   keyed_wdog dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .por_n      (por_n),
      .tick       (tick),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .wdog_count (wdog_count),
      .rst_req    (rst_req),
      .cause_flag (cause_flag)
   );

   always #4 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic push(input string tag);
      exp_t e;
      e.due = cyc + 1;
      e.cnt = m_cnt[7:0];
      e.rq  = m_rq;
      e.fl  = m_flag;
      e.tag = tag;
      q.push_back(e);
   endtask

   task automatic step(input logic we, input logic [1:0] a, input logic [7:0] d,
                       input logic tk, input string tag);
      logic clr, inc, ovf, bad, fire;
      @(negedge clk);
      wr_en = we; wr_addr = a; wr_data = d; tick = tk;
      clr  = we && a == 2'd0 && d == 8'hAA && m_armed;
      inc  = tk && m_run;
      ovf  = inc && !clr && m_cnt == 255;
      bad  = we && a == 2'd1 && d[4:2] != 3'b101;
      fire = m_mode && (ovf || bad);
      if (we && a == 2'd0) m_armed = (d == 8'h55);
      if (clr) m_cnt = 0;
      else if (inc) m_cnt = (m_cnt + 1) % 256;
      if (we && a == 2'd1 && !bad) begin
         m_run  = d[0];
         m_mode = d[1];
      end
      m_rq = fire;
      if (fire) m_flag = 1'b1;
      else if (we && a == 2'd2 && d[0]) m_flag = 1'b0;
      push(tag);
   endtask

   task automatic do_reset(input logic por, input string tag);
      @(negedge clk);
      wr_en = 1'b0; tick = 1'b0;
      rst_n = 1'b0;
      if (por) por_n = 1'b0;
      m_cnt = 0; m_armed = 1'b0; m_run = 1'b1; m_mode = 1'b1; m_rq = 1'b0;
      if (por) m_flag = 1'b0;
      push(tag);
      @(negedge clk);
      rst_n = 1'b1;
      por_n = 1'b1;
   endtask

   task automatic ticks(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, 2'd0, 8'h00, 1'b1, tag);
   endtask

   always @(negedge clk) begin
      while (q.size() > 0 && q[0].due <= cyc) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (wdog_count !== e.cnt || rst_req !== e.rq || cause_flag !== e.fl) begin
            errors++;
            $display("FAIL %s: cnt=%0d rq=%0b flag=%0b expected cnt=%0d rq=%0b flag=%0b",
                     e.tag, wdog_count, rst_req, cause_flag, e.cnt, e.rq, e.fl);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R1 power-on state
      do_reset(1'b1, "R1");
      step(1'b0, 2'd0, 8'h00, 1'b0, "R1");
      // R2 count and hold
      ticks(5, "R2");
      step(1'b0, 2'd0, 8'h00, 1'b0, "R2");
      step(1'b0, 2'd0, 8'h00, 1'b0, "R2");
      // R4 clear key while disarmed
      step(1'b1, 2'd0, 8'hAA, 1'b0, "R4");
      // R3 arm, clear, then a second clear key does nothing
      step(1'b1, 2'd0, 8'h55, 1'b0, "R3");
      step(1'b1, 2'd0, 8'hAA, 1'b0, "R3");
      ticks(3, "R2");
      step(1'b1, 2'd0, 8'hAA, 1'b0, "R3");
      // R5 repeated arm keys
      step(1'b1, 2'd0, 8'h55, 1'b0, "R5");
      step(1'b1, 2'd0, 8'h55, 1'b0, "R5");
      step(1'b1, 2'd0, 8'h55, 1'b0, "R5");
      step(1'b1, 2'd0, 8'hAA, 1'b0, "R5");
      // R6 stray key disarms
      ticks(4, "R2");
      step(1'b1, 2'd0, 8'h55, 1'b0, "R6");
      step(1'b1, 2'd0, 8'h32, 1'b0, "R6");
      step(1'b1, 2'd0, 8'hAA, 1'b0, "R6");
      // R11 key write alongside tick
      step(1'b1, 2'd0, 8'h55, 1'b1, "R11");
      step(1'b1, 2'd0, 8'hAA, 1'b1, "R11");
      // R7 wrap with reset request
      ticks(255, "R2");
      step(1'b0, 2'd0, 8'h00, 1'b1, "R7");
      step(1'b0, 2'd0, 8'h00, 1'b0, "R7");
      // R11 clear at 255 beats the wrap
      ticks(255, "R2");
      step(1'b1, 2'd0, 8'h55, 1'b0, "R11");
      step(1'b1, 2'd0, 8'hAA, 1'b1, "R11");
      step(1'b0, 2'd0, 8'h00, 1'b0, "R11");
      // R10 flag survives system reset, status write with bit0 clear
      do_reset(1'b0, "R10");
      step(1'b1, 2'd2, 8'h00, 1'b0, "R10");
      ticks(255, "R2");
      step(1'b0, 2'd0, 8'h00, 1'b1, "R10");
      step(1'b1, 2'd2, 8'h01, 1'b0, "R10");
      // R8 bad check bits, control unchanged
      ticks(2, "R2");
      step(1'b1, 2'd1, 8'h08, 1'b0, "R8");
      step(1'b0, 2'd0, 8'h00, 1'b1, "R8");
      step(1'b1, 2'd2, 8'h01, 1'b0, "R10");
      // R12 stop and restart
      step(1'b1, 2'd1, 8'h16, 1'b0, "R12");
      ticks(3, "R12");
      step(1'b1, 2'd1, 8'h17, 1'b0, "R12");
      step(1'b0, 2'd0, 8'h00, 1'b1, "R12");
      // R9 reset mode off
      step(1'b1, 2'd1, 8'h15, 1'b0, "R9");
      step(1'b1, 2'd1, 8'h01, 1'b0, "R9");
      ticks(260, "R9");
      // R10 power-on reset clears a set flag
      step(1'b1, 2'd1, 8'h17, 1'b0, "R9");
      step(1'b1, 2'd1, 8'h00, 1'b0, "R8");
      do_reset(1'b1, "R10");
      step(1'b0, 2'd0, 8'h00, 1'b0, "R1");
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      if (q.size() != 0) begin
         errors++;
         $display("FAIL drain: actual=%0d pending expected=0", q.size());
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule